// File: doc/BRIEF.md
# Time-Multiplexed 8-Tap FIR Filter

This block is an 8-tap FIR filter with fixed coefficients. Its datapath is clocked twice per input sample, so four multipliers cover all eight taps. Each sample period has two fast-clock phases. In the accept phase the filter takes a new sample into its delay line. In the next phase the four multipliers form the sum of the four newest taps with coefficients 0 to 3, and that partial sum is registered. In the following accept phase the same multipliers form the sum of the four oldest taps with coefficients 4 to 7, taken from the same delay-line snapshot. That sum is added to the held partial sum to give the output sample.

The source watches `ready` and presents a new sample on `din` whenever `ready` is high. A sample is taken on a rising edge where `ready` and `ce` are both high. The clock enable freezes the whole block. The reset is synchronous and clears all history.

Top module: `tdm_fir8`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ready` is 1, `dout` is 0 and `dout_vld` is 0. All eight taps of history read as zero.
- R2: On every rising edge with `ce` high, `ready` toggles. A sample on `din` is taken only on an edge where `ready` and `ce` are both 1. A value on `din` while `ready` is 0 has no effect.
- R3: Each result equals the sum over i from 0 to 7 of c[i]·x[n−i]. Here x[n] is the newest accepted sample and c = {131071, −131072, 100000, −77777, 54321, −12345, 2047, −131072}, indexed 0 to 7. All values are signed two's complement.
- R4: The result for a sample accepted at enabled edge E appears on `dout` after the second enabled edge following E. `dout_vld` is 1 for exactly that one enabled cycle, and it is 0 whenever `ready` is 1.
- R5: After reset, the first accepted sample does not raise `dout_vld` on its own acceptance edge. The outputs that follow treat samples from before the reset as zero.
- R6: While `ce` is 0, `ready`, `dout` and `dout_vld` hold their values, and no sample is taken.
- R7: `dout` is 39 bits wide and signed, and it holds the full-scale result without overflow. This includes every product at its largest magnitude with the same sign.
- R8: Coefficient c[0] pairs with the newest sample, and c[k] pairs with the sample k acceptances older. A single nonzero sample followed by zeros therefore yields s·c[0], s·c[1], …, s·c[7] in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, two cycles per sample |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for all state |
| din | input | DW (18) | Signed input sample |
| ready | output | 1 | High in the accept phase; `din` is taken on that edge if `ce` is high |
| dout | output | DW+21 (39) | Signed filter result |
| dout_vld | output | 1 | Marks the cycle in which a new result is first shown |

## Verification
The hardest case to reach is a clock-enable stall that lands between the two halves of one computation. The first partial sum is then held in its register while the result of the previous sample stays on the output with its valid strobe still high. The bench drops `ce` for several cycles right after it observes a result in the compute phase. It also stalls in the accept phase while driving a junk value on `din`. The outputs that follow must still match the model, which shows that the held partial sum was kept and that the junk value was never taken into the delay line.

// File: rtl/tdm_fir8.sv
module tdm_fir8 #(
  parameter int DW = 18
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ce,
  input  logic signed [DW-1:0]     din,
  output logic                     ready,
  output logic signed [DW+20:0]    dout,
  output logic                     dout_vld
);
  localparam int TAPS = 8;
  localparam int HALF = TAPS / 2;
  localparam int CW   = 18;
  localparam int PW   = DW + CW;
  localparam int SW   = PW + $clog2(HALF);
  localparam int RW   = SW + 1;
  localparam int COEF [TAPS] = '{131071, -131072, 100000, -77777, 54321, -12345, 2047, -131072};

  logic                 ph;
  logic                 started;
  logic signed [DW-1:0] tap [TAPS];
  logic signed [DW-1:0] tsel [HALF];
  logic signed [CW-1:0] csel [HALF];
  logic signed [PW-1:0] prod [HALF];
  logic signed [SW-1:0] half_sum;
  logic signed [SW-1:0] part_q;
  logic signed [RW-1:0] res_q;
  logic                 vld_q;

  assign ready    = ~ph;
  assign dout     = res_q;
  assign dout_vld = vld_q;

  for (genvar k = 0; k < HALF; k++) begin : g_mul
    localparam logic signed [CW-1:0] CLO = CW'(COEF[k]);
    localparam logic signed [CW-1:0] CHI = CW'(COEF[k+HALF]);
    assign tsel[k] = ph ? tap[k] : tap[k+HALF];
    assign csel[k] = ph ? CLO : CHI;
    assign prod[k] = tsel[k] * csel[k];
  end

  always_comb begin
    half_sum = '0;
    for (int k = 0; k < HALF; k++)
      half_sum = half_sum + {{(SW-PW){prod[k][PW-1]}}, prod[k]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= 1'b0;
      started <= 1'b0;
      part_q  <= '0;
      res_q   <= '0;
      vld_q   <= 1'b0;
      for (int i = 0; i < TAPS; i++) tap[i] <= '0;
    end else if (ce) begin
      ph    <= ~ph;
      vld_q <= ~ph & started;
      if (!ph) begin
        tap[0]  <= din;
        for (int i = 1; i < TAPS; i++) tap[i] <= tap[i-1];
        started <= 1'b1;
        if (started)
          res_q <= {part_q[SW-1], part_q} + {half_sum[SW-1], half_sum};
      end else begin
        part_q <= half_sum;
      end
    end
  end

  assert_ready_toggles_R2: assert property (@(posedge clk) disable iff (rst)
    ce |=> (ready != $past(ready)));
  assert_vld_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
    (ce && dout_vld) |=> !dout_vld);
  assert_vld_not_in_accept_R4: assert property (@(posedge clk) disable iff (rst)
    dout_vld |-> !ready);
  assert_dout_moves_with_vld_R4: assert property (@(posedge clk) disable iff (rst)
    !dout_vld |-> $stable(dout));
  assert_stall_holds_R6: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(dout) && $stable(ready) && $stable(dout_vld)));
  assert_no_early_vld_R5: assert property (@(posedge clk) disable iff (rst)
    !started |=> !dout_vld);
endmodule

// File: tb/tdm_fir8_tb.sv
`timescale 1ns/1ps
module tdm_fir8_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce = 1'b0;
  logic signed [17:0] din = '0;
  logic ready;
  logic signed [38:0] dout;
  logic dout_vld;

  tdm_fir8 u_dut (.clk(clk), .rst(rst), .ce(ce), .din(din),
                  .ready(ready), .dout(dout), .dout_vld(dout_vld));

  always #2 clk = ~clk;

  longint C [8] = '{131071, -131072, 100000, -77777, 54321, -12345, 2047, -131072};
  longint hist [8];
  bit     pend_v;
  longint pend_e;
  int     nchk = 0;
  int     nerr = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; ce = 1'b1; din = 18'sd777;
    repeat (3) @(negedge clk);
    chk(ready == 1'b1, "R1 ready in reset", ready, 1);
    chk(dout == 0, "R1 dout in reset", dout, 0);
    chk(dout_vld == 1'b0, "R1 vld in reset", dout_vld, 0);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) hist[i] = 0;
    pend_v = 1'b0;
    chk(ready == 1'b1 && dout == 0 && dout_vld == 1'b0, "R1 after release", dout, 0);
  endtask

  task automatic feed(input logic signed [17:0] s, input string req, input int hold);
    longint e;
    logic signed [38:0] hd;
    logic hv;
    chk(ready == 1'b1, "R2 ready in accept phase", ready, 1);
    chk(dout_vld == 1'b0, "R4 vld low in accept phase", dout_vld, 0);
    din = s;
    for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = s;
    e = 0;
    for (int i = 0; i < 8; i++) e += C[i] * hist[i];
    @(negedge clk);
    din = ~s;
    chk(ready == 1'b0, "R2 ready toggled", ready, 0);
    if (pend_v) begin
      chk(dout_vld == 1'b1, {req, " R4 vld"}, dout_vld, 1);
      chk(longint'(dout) == pend_e, req, longint'(dout), pend_e);
    end else begin
      chk(dout_vld == 1'b0, "R5 no vld on first acceptance", dout_vld, 0);
    end
    if (hold > 0) begin
      hd = dout; hv = dout_vld; ce = 1'b0;
      repeat (hold) begin
        @(negedge clk);
        chk(dout == hd && dout_vld == hv && ready == 1'b0, "R6 hold in compute phase",
            longint'(dout), longint'(hd));
      end
      ce = 1'b1;
    end
    pend_v = 1'b1;
    pend_e = e;
    @(negedge clk);
  endtask

  task automatic stall_accept(input int n);
    logic signed [38:0] hd;
    hd = dout;
    ce = 1'b0;
    din = 18'sh1ABCD;
    repeat (n) begin
      @(negedge clk);
      chk(ready == 1'b1 && dout_vld == 1'b0 && dout == hd, "R6 hold in accept phase",
          longint'(dout), longint'(hd));
    end
    ce = 1'b1;
  endtask

  task automatic t_impulse();
    do_reset();
    feed(18'sd1000, "R8 impulse", 0);
    for (int k = 0; k < 9; k++) feed(18'sd0, "R8 impulse tail", 0);
    feed(-18'sd131072, "R8 neg impulse", 0);
    for (int k = 0; k < 9; k++) feed(18'sd0, "R8 neg impulse tail", 0);
  endtask

  task automatic t_random();
    for (int k = 0; k < 40; k++) feed(18'($urandom), "R3 random", 0);
  endtask

  task automatic t_fullscale();
    for (int i = 7; i >= 0; i--) feed(C[i] >= 0 ? 18'sd131071 : -18'sd131072, "R7 max", 0);
    feed(18'sd131071, "R7 max", 0);
    for (int i = 7; i >= 0; i--) feed(C[i] >= 0 ? -18'sd131072 : 18'sd131071, "R7 min", 0);
    feed(-18'sd131072, "R7 min", 0);
    for (int i = 0; i < 8; i++) feed(-18'sd131072, "R7 all min", 0);
  endtask

  task automatic t_stall();
    for (int k = 0; k < 6; k++) begin
      feed(18'($urandom), "R6 after stall", k % 3 + 1);
      stall_accept(k % 2 + 2);
    end
    feed(18'sd5, "R6 flush", 0);
    feed(18'sd0, "R6 flush", 0);
  endtask

  task automatic t_reset_mid();
    for (int k = 0; k < 5; k++) feed(18'sd60000, "R3 prefill", 0);
    do_reset();
    feed(18'sd3, "R5 first after reset", 0);
    feed(18'sd0, "R5 zero history", 0);
    feed(18'sd0, "R5 zero history", 0);
  endtask

  initial begin
    do_reset();
    t_impulse();
    t_random();
    t_fullscale();
    t_stall();
    t_reset_mid();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #400000;
    nerr++;
    nchk++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule